// File: doc/BRIEF.md
# Display List Sequencer

This block walks a display list held in a 4096-word, 12-bit refresh memory. It reads one word per memory cycle and classifies each word. A word can be picture data, a one-word jump within a page, a two-word absolute jump, or a channel-select instruction. Data words go to one of several display generators. The list loops and branches through the jumps embedded in it, so a host can edit or switch the picture without stopping the refresh.

Memory reads go through a start/done interface. The sequencer drives a read address and a one-cycle `mem_start` pulse. The memory later returns the word with a one-cycle `mem_done` pulse. Each generator reports an asynchronous idle level and receives a one-cycle strobe. While the strobe is high, the 11 payload bits and the 7 control bits of the current channel are valid. A busy generator paces the list: the sequencer holds the word and starts no read until that generator is idle again.

Bits are numbered from the most significant bit of the word (word bit 11). Location 0 normally holds an absolute jump, and location 1 holds a pointer to the file to show.

Top module: `dlist_seq`

## Requirements
- R1: After reset, `mem_start` and `gen_strobe` are low and `mem_addr` is 0. In the idle state, `go` clears the address, the buffer, the channel (to generator 0, control 0) and the pending-pointer flag. On the next edge it issues the first read of address 0.
- R2: A word with bit 11 = 0 is data. The address advances by one. The generator of the current channel gets a one-cycle strobe, and `gen_data` carries word bits 10..0 during the strobe. At most one strobe bit is high at a time.
- R3: A word with bits 11..10 = 10 selects a channel. Bits 9..7 name the generator and bits 6..0 appear on `gen_ctrl`. All following data words go to that generator until the next channel-select word. The address advances by one.
- R4: A word with bits 11..9 = 110 and bit 8 = 1 is a direct jump within the current page. The next address keeps address bits 11..8 and takes word bits 7..0 as its low byte.
- R5: A word with bits 11..9 = 110 and bit 8 = 0 is a direct jump into page 0. The next address is {4'b0, word bits 7..0}.
- R6: A word with bits 11..9 = 111 is an absolute jump. The next location is read, and that word is loaded in full as the new address without being decoded, whatever its bit pattern.
- R7: If the selected generator is busy when a data word arrives, the address still advances. No strobe and no read request are issued until the generator reports idle. Then the strobe and the next read follow.
- R8: When no stall occurs, the next `mem_start` is asserted on the second rising edge after the edge that captured `mem_done`, for every word kind.
- R9: While the channel names a generator number at or above `NGEN`, data words are dropped without a strobe and without stalling.
- R10: `halt` has priority over everything else and re-initialises all registers and flags. From the next edge on there is no read request and no strobe, and `mem_addr` is 0.
- R11: The idle inputs pass through two synchronising flops before they can release a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, honoured while idle |
| halt | input | 1 | Stop pulse, re-initialises the block |
| mem_start | output | 1 | One-cycle read request |
| mem_addr | output | 12 | Read address, valid with `mem_start` |
| mem_done | input | 1 | One-cycle pulse, read word valid |
| mem_rdata | input | 12 | Word returned by the memory |
| gen_idle | input | NGEN | Asynchronous idle level per generator |
| gen_strobe | output | NGEN | One-hot, one-cycle read strobe per generator |
| gen_data | output | 11 | Payload of the current data word |
| gen_ctrl | output | 7 | Control bits of the current channel |

## Verification
Every word's outcome is due two rising edges after the edge that captured `mem_done`. That outcome is either a strobe or a read request, or both in the same cycle for an un-stalled data word. A release of a busy generator takes two synchroniser edges plus one more before the strobe and the read appear. The bench samples on the falling edge. A scoreboard queues the expected address sequence and the expected strobes with their generator, payload and control bits. A monitor pops the queues as requests and strobes appear. The monitor also measures the done-to-start distance on every word outside a stall. During a deliberate stall, the bench checks the held address and the absence of requests over a fixed window before it releases the generator.

// File: rtl/dls_pkg.sv
package dls_pkg;

    localparam int WORD_W = 12;
    localparam int ADDR_W = 12;
    localparam int PAGE_W = 4;
    localparam int OFS_W  = ADDR_W - PAGE_W;
    localparam int SEL_W  = 3;
    localparam int CTRL_W = 7;
    localparam int PAY_W  = WORD_W - 1;
    localparam int MAX_GEN = 1 << SEL_W;

    // field positions (LSB numbering, word bit 11 is the first bit)
    localparam int B_INSTR = WORD_W - 1;
    localparam int B_JUMP  = WORD_W - 2;
    localparam int B_INDIR = WORD_W - 3;
    localparam int B_KEEP  = WORD_W - 4;

    typedef enum logic [1:0] {
        K_DATA  = 2'd0,
        K_CHAN  = 2'd1,
        K_DJUMP = 2'd2,
        K_IJUMP = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic               keep_page;
        logic [OFS_W-1:0]   ofs;
        logic [SEL_W-1:0]   sel;
        logic [CTRL_W-1:0]  ctrl;
        logic [PAY_W-1:0]   payload;
    } word_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WAIT   = 2'd1,
        S_DECODE = 2'd2,
        S_STALL  = 2'd3
    } state_e;

    function automatic word_t split_word(input logic [WORD_W-1:0] w);
        word_t r;
        if (!w[B_INSTR])     r.kind = K_DATA;
        else if (!w[B_JUMP]) r.kind = K_CHAN;
        else if (!w[B_INDIR]) r.kind = K_DJUMP;
        else                 r.kind = K_IJUMP;
        r.keep_page = w[B_KEEP];
        r.ofs       = w[OFS_W-1:0];
        r.sel       = w[CTRL_W+SEL_W-1:CTRL_W];
        r.ctrl      = w[CTRL_W-1:0];
        r.payload   = w[PAY_W-1:0];
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] direct_target(
        input logic [ADDR_W-1:0] cur,
        input logic              keep,
        input logic [OFS_W-1:0]  ofs);
        logic [PAGE_W-1:0] page;
        page = keep ? cur[ADDR_W-1:OFS_W] : '0;
        return {page, ofs};
    endfunction

endpackage

// File: rtl/dls_sync.sv
module dls_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dls_decode.sv
module dls_decode
    import dls_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output word_t             fields
);
    always_comb fields = split_word(word);
endmodule

// File: rtl/dls_strobe.sv
module dls_strobe
    import dls_pkg::*;
#(
    parameter int NGEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [SEL_W-1:0] sel,
    output logic [NGEN-1:0]  strobe
);
    generate
        for (genvar g = 0; g < NGEN; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) strobe[g] <= 1'b0;
                else     strobe[g] <= fire && (int'(sel) == g);
            end
        end
    endgenerate
endmodule

// File: rtl/dlist_seq.sv
module dlist_seq
    import dls_pkg::*;
#(
    parameter int NGEN        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              halt,
    output logic              mem_start,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_done,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [NGEN-1:0]   gen_idle,
    output logic [NGEN-1:0]   gen_strobe,
    output logic [PAY_W-1:0]  gen_data,
    output logic [CTRL_W-1:0] gen_ctrl
);
    state_e             state;
    logic [ADDR_W-1:0]  dar;
    logic [WORD_W-1:0]  dbr;
    logic [SEL_W-1:0]   mode;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               ptr_pending;

    logic [NGEN-1:0]    idle_s;
    logic [MAX_GEN-1:0] idle_ext;
    logic               mode_valid;
    logic               gen_ready;
    word_t              dw;
    logic               is_data;
    logic               fire;

    dls_sync #(.W(NGEN), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (gen_idle),
        .q_sync  (idle_s)
    );

    dls_decode i_decode (
        .word   (dbr),
        .fields (dw)
    );

    always_comb begin
        idle_ext = '0;
        idle_ext[NGEN-1:0] = idle_s;
    end

    assign mode_valid = int'(mode) < NGEN;
    assign gen_ready  = idle_ext[mode];
    assign is_data    = (state == S_DECODE) && !ptr_pending && (dw.kind == K_DATA);
    assign fire       = !rst && !halt && mode_valid && gen_ready &&
                        (is_data || (state == S_STALL));

    dls_strobe #(.NGEN(NGEN)) i_strobe (
        .clk    (clk),
        .rst    (rst || halt),
        .fire   (fire),
        .sel    (mode),
        .strobe (gen_strobe)
    );

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            state       <= S_IDLE;
            dar         <= '0;
            dbr         <= '0;
            mode        <= '0;
            ctrl_q      <= '0;
            ptr_pending <= 1'b0;
            mem_start   <= 1'b0;
        end else begin
            mem_start <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (go) begin
                        dar         <= '0;
                        dbr         <= '0;
                        mode        <= '0;
                        ctrl_q      <= '0;
                        ptr_pending <= 1'b0;
                        mem_start   <= 1'b1;
                        state       <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (mem_done) begin
                        dbr   <= mem_rdata;
                        state <= S_DECODE;
                    end
                end
                S_DECODE: begin
                    if (ptr_pending) begin
                        dar         <= dbr;
                        ptr_pending <= 1'b0;
                        mem_start   <= 1'b1;
                        state       <= S_WAIT;
                    end else begin
                        case (dw.kind)
                            K_DATA: begin
                                dar <= dar + 1'b1;
                                if (!mode_valid || gen_ready) begin
                                    mem_start <= 1'b1;
                                    state     <= S_WAIT;
                                end else begin
                                    state <= S_STALL;
                                end
                            end
                            K_CHAN: begin
                                mode      <= dw.sel;
                                ctrl_q    <= dw.ctrl;
                                dar       <= dar + 1'b1;
                                mem_start <= 1'b1;
                                state     <= S_WAIT;
                            end
                            K_DJUMP: begin
                                dar       <= direct_target(dar, dw.keep_page, dw.ofs);
                                mem_start <= 1'b1;
                                state     <= S_WAIT;
                            end
                            default: begin
                                dar         <= dar + 1'b1;
                                ptr_pending <= 1'b1;
                                mem_start   <= 1'b1;
                                state       <= S_WAIT;
                            end
                        endcase
                    end
                end
                S_STALL: begin
                    if (gen_ready) begin
                        mem_start <= 1'b1;
                        state     <= S_WAIT;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign mem_addr = dar;
    assign gen_data = dbr[PAY_W-1:0];
    assign gen_ctrl = ctrl_q;

endmodule

// File: rtl/dlist_seq_chk.sv
module dlist_seq_chk
    import dls_pkg::*;
#(
    parameter int NGEN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              go,
    input logic              halt,
    input logic              mem_start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NGEN-1:0]   gen_strobe,
    input logic [PAY_W-1:0]  gen_data
);
    logic active;

    always_ff @(posedge clk) begin
        if (rst || halt) active <= 1'b0;
        else if (go)     active <= 1'b1;
    end

    // R1
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !halt && !active) |=> (mem_start && mem_addr == '0));

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> (!mem_start && mem_addr == '0 && gen_strobe == '0));

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gen_strobe));

    // R2
    data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_strobe != '0) |-> $stable(gen_data));

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_start |=> !mem_start);

endmodule

bind dlist_seq dlist_seq_chk #(.NGEN(NGEN)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .halt       (halt),
    .mem_start  (mem_start),
    .mem_addr   (mem_addr),
    .gen_strobe (gen_strobe),
    .gen_data   (gen_data)
);

// File: tb/test_dlist_seq.sv
module test_dlist_seq;
    localparam int NGEN = 4;
    localparam int LAT  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic        halt = 1'b0;
    logic        mem_start;
    logic [11:0] mem_addr;
    logic        mem_done = 1'b0;
    logic [11:0] mem_rdata = '0;
    logic [NGEN-1:0] gen_idle = '1;
    logic [NGEN-1:0] gen_strobe;
    logic [10:0] gen_data;
    logic [6:0]  gen_ctrl;

    dlist_seq #(.NGEN(NGEN)) i_dlist_seq (
        .clk(clk), .rst(rst), .go(go), .halt(halt),
        .mem_start(mem_start), .mem_addr(mem_addr),
        .mem_done(mem_done), .mem_rdata(mem_rdata),
        .gen_idle(gen_idle), .gen_strobe(gen_strobe),
        .gen_data(gen_data), .gen_ctrl(gen_ctrl)
    );

    always #5 clk = ~clk;

    // memory model
    logic [11:0] mem [int];
    int          lat_cnt = 0;
    logic [11:0] lat_addr = '0;

    function automatic logic [11:0] rd(input logic [11:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 12'h000;
    endfunction

    always @(posedge clk) begin
        mem_done <= 1'b0;
        if (rst) begin
            lat_cnt <= 0;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                mem_done  <= 1'b1;
                mem_rdata <= rd(lat_addr);
            end
        end else if (mem_start) begin
            lat_cnt  <= LAT;
            lat_addr <= mem_addr;
        end
    end

    // scoreboard
    int    n_checks = 0;
    int    n_fail = 0;
    int    exp_gen[$];
    int    exp_data[$];
    int    exp_ctrl[$];
    string exp_stag[$];
    int    exp_addr[$];
    string exp_atag[$];

    int cyc = 0;
    int last_done = 0;
    bit dflag = 0;
    bit skip_gap = 0;
    int strobe_cnt = 0;
    int start_cnt = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic push_strobe(input int g, input int d, input int c, input string tag);
        exp_gen.push_back(g);
        exp_data.push_back(d);
        exp_ctrl.push_back(c);
        exp_stag.push_back(tag);
    endtask

    task automatic push_addr(input int a, input string tag);
        exp_addr.push_back(a);
        exp_atag.push_back(tag);
    endtask

    // monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (mem_done) begin
                last_done = cyc;
                dflag = 1;
            end
            if (mem_start) begin
                start_cnt++;
                if (dflag) begin
                    if (skip_gap) skip_gap = 0;
                    else check(cyc - last_done == 2, "R8", "done-to-start cycles",
                               cyc - last_done, 2);
                end
                dflag = 0;
                if (exp_addr.size() != 0) begin
                    automatic int    a = exp_addr.pop_front();
                    automatic string t = exp_atag.pop_front();
                    check(int'(mem_addr) == a, t, "read address", int'(mem_addr), a);
                end
            end
            if (gen_strobe != '0) begin
                automatic int g = -1;
                strobe_cnt++;
                check($countones(gen_strobe) == 1, "R2", "strobe one-hot",
                      int'(gen_strobe), 1);
                for (int i = 0; i < NGEN; i++) if (gen_strobe[i]) g = i;
                if (exp_gen.size() == 0) begin
                    check(1'b0, "R9", "unexpected strobe", g, -1);
                end else begin
                    automatic int    eg = exp_gen.pop_front();
                    automatic int    ed = exp_data.pop_front();
                    automatic int    ec = exp_ctrl.pop_front();
                    automatic string t  = exp_stag.pop_front();
                    check(g == eg, t, "strobe generator", g, eg);
                    check(int'(gen_data) == ed, "R2", "strobe payload", int'(gen_data), ed);
                    check(int'(gen_ctrl) == ec, "R3", "channel control", int'(gen_ctrl), ec);
                end
            end
        end
    end

    task automatic summary_and_end();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary_and_end();
    end

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_gen.size() != 0 || exp_addr.size() != 0) @(negedge clk);
    endtask

    initial begin
        int s0;
        // file 1 layout
        mem[12'h000] = 12'hE00;  // absolute jump
        mem[12'h001] = 12'h100;  // pointer
        mem[12'h100] = 12'h895;  // channel gen1, ctrl 0x15
        mem[12'h101] = 12'h123;
        mem[12'h102] = 12'h7FF;
        mem[12'h103] = 12'hDF0;  // direct, keep page -> 0x1F0
        mem[12'h1F0] = 12'h900;  // channel gen2
        mem[12'h1F1] = 12'h456;
        mem[12'h1F2] = 12'hB80;  // channel gen7 (absent)
        mem[12'h1F3] = 12'h0AA;  // dropped
        mem[12'h1F4] = 12'h800;  // channel gen0
        mem[12'h1F5] = 12'h001;
        mem[12'h1F6] = 12'hC00;  // direct, page 0 -> 0x000

        gen_idle = 4'b1101;      // generator 1 busy
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(mem_start == 1'b0, "R1", "reset mem_start", int'(mem_start), 0);
        check(gen_strobe == '0, "R1", "reset strobe", int'(gen_strobe), 0);
        check(mem_addr == 12'h000, "R1", "reset address", int'(mem_addr), 0);

        for (int l = 0; l < 2; l++) begin
            push_addr(12'h000, "R1");
            push_addr(12'h001, "R6");
            push_addr(12'h100, "R6");
            push_addr(12'h101, "R3");
            push_addr(12'h102, "R2");
            push_addr(12'h103, "R2");
            push_addr(12'h1F0, "R4");
            push_addr(12'h1F1, "R3");
            push_addr(12'h1F2, "R2");
            push_addr(12'h1F3, "R3");
            push_addr(12'h1F4, "R9");
            push_addr(12'h1F5, "R3");
            push_addr(12'h1F6, "R2");
            push_strobe(1, 12'h123, 7'h15, "R3");
            push_strobe(1, 12'h7FF, 7'h15, "R3");
            push_strobe(2, 12'h456, 7'h00, "R3");
            push_strobe(0, 12'h001, 7'h00, "R9");
        end
        push_addr(12'h000, "R5");

        dflag = 0;
        pulse(go);
        repeat (60) @(negedge clk);
        // R7 stall on busy generator 1
        check(strobe_cnt == 0, "R7", "strobes while busy", strobe_cnt, 0);
        check(mem_addr == 12'h102, "R7", "address advanced before stall",
              int'(mem_addr), 12'h102);
        s0 = start_cnt;
        skip_gap = 1;
        repeat (30) @(negedge clk);
        check(start_cnt == s0, "R7", "reads during stall", start_cnt, s0);
        gen_idle = 4'b1111;
        // R11 release needs synchroniser delay
        @(negedge clk);
        check(strobe_cnt == 0, "R11", "strobe one cycle after release", strobe_cnt, 0);
        wait_drain();

        // R10 halt
        pulse(halt);
        s0 = start_cnt;
        check(mem_addr == 12'h000, "R10", "address after halt", int'(mem_addr), 0);
        repeat (20) @(negedge clk);
        check(start_cnt == s0, "R10", "reads after halt", start_cnt, s0);
        check(gen_strobe == '0, "R10", "strobe after halt", int'(gen_strobe), 0);

        // file 2: pointer looks like an instruction (R6), page-keeping jump (R4)
        mem[12'h001] = 12'hA10;
        mem[12'hA10] = 12'h0F0;
        mem[12'hA11] = 12'hD00;  // keep page -> 0xA00
        mem[12'hA00] = 12'hC00;  // page 0 -> 0x000
        for (int l = 0; l < 2; l++) begin
            push_addr(12'h000, "R5");
            push_addr(12'h001, "R6");
            push_addr(12'hA10, "R6");
            push_addr(12'hA11, "R2");
            push_addr(12'hA00, "R4");
            push_strobe(0, 12'h0F0, 7'h00, "R1");
        end
        push_addr(12'h000, "R5");
        dflag = 0;
        pulse(go);
        wait_drain();
        pulse(halt);
        repeat (10) @(negedge clk);
        summary_and_end();
    end
endmodule